// File: doc/BRIEF.md
# Eye-Margin Early/Late Monitor

This block watches a digital picture of the data eye on several lanes at once. On every clock, each lane presents one sample taken at the clock edge and two rows of samples taken at successive delay steps away from it: one row on the early side and one on the late side. The block looks for a data transition that sits closer to the clock edge than a programmable guard distance. When it finds one on the early side, it sets that lane's early flag. When it finds one on the late side, it sets the late flag. An early flag tells the delay loop to reduce the lane's delay, and a late flag tells it to increase the delay.

Both flags are sticky. They stay set until the fabric pulses a clear, which it does once it has adjusted the delay in response. The guard distance comes from a 3-bit code and may change on any cycle. Sweeping that code while watching the flags shows how wide the eye is open.

Top module: `eye_margin_monitor`

## Requirements
- R1: The guard length G taken from `guard_code` is code+1 for codes 0 to 5, and 8 for codes 6 and 7.
- R2: For lane L, the edge sample is `edge_smp_i[L]`. Early-side sample k is `early_smp_i[8*L+k]` and late-side sample k is `late_smp_i[8*L+k]`, with k=0 the one nearest the edge. On each side, step 1 compares the edge sample with sample 0, and step j (2 to 8) compares sample j-2 with sample j-1.
- R3: If the early side has any step j <= G whose two samples differ, `early_flag_o[L]` is 1 after the next rising clock edge.
- R4: If the late side has any step j <= G whose two samples differ, `late_flag_o[L]` is 1 after the next rising clock edge.
- R5: A differing step j > G has no effect: a flag that is clear stays clear.
- R6: A set flag stays set while `clear_i` is 0, whatever samples arrive.
- R7: With `clear_i` at 1 and no detection on that lane and side, the flag is 0 after the next rising edge.
- R8: When a detection and `clear_i` occur in the same cycle, the flag is 1 after the edge.
- R9: Both flags of a lane can set in the same cycle, and each lane acts independently of the others.
- R10: While `rst` is high, all flags are 0 after each rising edge.
- R11: A change of `guard_code` applies to the samples presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| guard_code | input | 3 | Guard length code (R1) |
| clear_i | input | 1 | Clears all flags once the delay has been adjusted |
| edge_smp_i | input | NUM_LANES | Sample at the clock edge, one per lane |
| early_smp_i | input | 8*NUM_LANES | Early-side samples, 8 per lane |
| late_smp_i | input | 8*NUM_LANES | Late-side samples, 8 per lane |
| early_flag_o | output | NUM_LANES | Sticky early flag per lane |
| late_flag_o | output | NUM_LANES | Sticky late flag per lane |

## Verification
Each flag is a one-bit register, and it can be seen one cycle after the samples that drive it. So a wrong guard mask, a wrong pair position or a wrong priority between set and clear shows up on the flag port at the very next edge. Because the flags are sticky, a stuck-high or stuck-low bit shows up in the first quiet cycle that follows a clear or a detection. Single-transition patterns, swept over every code and every step, catch an off-by-one in the mask. Random sparse patterns cover the mix of lanes, sides and clears.

// File: rtl/eye_mon_pkg.sv
package eye_mon_pkg;

    localparam int SIDE_N   = 8;
    localparam int CODE_W   = 3;
    localparam int LAST_LIN = 5;

    typedef logic [SIDE_N-1:0] side_vec_t;

    typedef struct packed {
        logic      centre;
        side_vec_t early;
        side_vec_t late;
    } lane_smp_t;

    typedef struct packed {
        logic early_hit;
        logic late_hit;
    } lane_hit_t;

    function automatic int guard_len(input logic [CODE_W-1:0] code);
        if (int'(code) <= LAST_LIN)
            return int'(code) + 1;
        return SIDE_N;
    endfunction

    function automatic side_vec_t guard_mask(input logic [CODE_W-1:0] code);
        side_vec_t m;
        int        n;
        n = guard_len(code);
        for (int i = 0; i < SIDE_N; i++)
            m[i] = (i < n);
        return m;
    endfunction

endpackage

// File: rtl/eye_guard_decode.sv
module eye_guard_decode
    import eye_mon_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output side_vec_t         mask
);
    always_comb mask = guard_mask(code);
endmodule

// File: rtl/eye_side_detect.sv
module eye_side_detect
    import eye_mon_pkg::*;
(
    input  logic      centre,
    input  side_vec_t smp,
    input  side_vec_t mask,
    output logic      hit
);
    side_vec_t diff;

    always_comb begin
        diff[0] = centre ^ smp[0];
        for (int k = 1; k < SIDE_N; k++)
            diff[k] = smp[k] ^ smp[k-1];
        hit = |(diff & mask);
    end
endmodule

// File: rtl/eye_sticky_flag.sv
module eye_sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic clear,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)        flag <= 1'b0;
        else if (hit)   flag <= 1'b1;
        else if (clear) flag <= 1'b0;
    end

    a_r8_hit_sets_flag: assert property (@(posedge clk) disable iff (rst)
        hit |=> flag);
    a_r6_flag_holds: assert property (@(posedge clk) disable iff (rst)
        (flag && !clear) |=> flag);
    a_r7_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (clear && !hit) |=> !flag);
    a_r5_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
        (!flag && !hit) |=> !flag);
    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> !flag);
endmodule

// File: rtl/eye_margin_monitor.sv
module eye_margin_monitor
    import eye_mon_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [CODE_W-1:0]           guard_code,
    input  logic                        clear_i,
    input  logic [NUM_LANES-1:0]        edge_smp_i,
    input  logic [NUM_LANES*SIDE_N-1:0] early_smp_i,
    input  logic [NUM_LANES*SIDE_N-1:0] late_smp_i,
    output logic [NUM_LANES-1:0]        early_flag_o,
    output logic [NUM_LANES-1:0]        late_flag_o
);
    side_vec_t mask;

    eye_guard_decode u_decode (
        .code (guard_code),
        .mask (mask)
    );

    a_r1_mask_shape: assert property (@(posedge clk) disable iff (rst)
        mask[0] && ($countones(mask) != 7)
        && ((mask & (mask + side_vec_t'(1))) == '0));

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        lane_smp_t smp;
        lane_hit_t hits;

        assign smp.centre = edge_smp_i[l];
        assign smp.early  = early_smp_i[l*SIDE_N +: SIDE_N];
        assign smp.late   = late_smp_i[l*SIDE_N +: SIDE_N];

        eye_side_detect u_early_det (
            .centre (smp.centre),
            .smp    (smp.early),
            .mask   (mask),
            .hit    (hits.early_hit)
        );

        eye_side_detect u_late_det (
            .centre (smp.centre),
            .smp    (smp.late),
            .mask   (mask),
            .hit    (hits.late_hit)
        );

        eye_sticky_flag u_early_flag (
            .clk   (clk),
            .rst   (rst),
            .hit   (hits.early_hit),
            .clear (clear_i),
            .flag  (early_flag_o[l])
        );

        eye_sticky_flag u_late_flag (
            .clk   (clk),
            .rst   (rst),
            .hit   (hits.late_hit),
            .clear (clear_i),
            .flag  (late_flag_o[l])
        );

        // R5: samples all equal to the edge sample never raise a flag from clear
        a_r5_quiet_lane: assert property (@(posedge clk) disable iff (rst)
            (!early_flag_o[l] && (smp.early == {SIDE_N{smp.centre}})) |=> !early_flag_o[l]);
    end
endmodule

// File: tb/tb_eye_margin_monitor.sv
`timescale 1ns/1ps
module tb_eye_margin_monitor;

    localparam int NL = 4;
    localparam int SN = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic [2:0]        guard_code;
    logic              clear_i;
    logic [NL-1:0]     edge_smp_i;
    logic [NL*SN-1:0]  early_smp_i;
    logic [NL*SN-1:0]  late_smp_i;
    logic [NL-1:0]     early_flag_o;
    logic [NL-1:0]     late_flag_o;

    int n_cmp = 0;
    int n_bad = 0;

    logic [NL-1:0] m_early = '0;
    logic [NL-1:0] m_late  = '0;

    always #5 clk = ~clk;

    eye_margin_monitor #(.NUM_LANES(NL)) dut (
        .clk          (clk),
        .rst          (rst),
        .guard_code   (guard_code),
        .clear_i      (clear_i),
        .edge_smp_i   (edge_smp_i),
        .early_smp_i  (early_smp_i),
        .late_smp_i   (late_smp_i),
        .early_flag_o (early_flag_o),
        .late_flag_o  (late_flag_o)
    );

    function automatic int exp_len(input logic [2:0] c);
        case (c)
            3'd6, 3'd7: return 8;
            default:    return int'(c) + 1;
        endcase
    endfunction

    function automatic logic side_hit(input logic c, input logic [SN-1:0] s,
                                      input logic [2:0] code);
        logic prev;
        prev = c;
        for (int j = 1; j <= exp_len(code); j++) begin
            if (s[j-1] != prev) return 1'b1;
            prev = s[j-1];
        end
        return 1'b0;
    endfunction

    task automatic check(input string tag, input logic [NL-1:0] act,
                         input logic [NL-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        for (int l = 0; l < NL; l++) begin
            logic eh, lh;
            eh = side_hit(edge_smp_i[l], early_smp_i[l*SN +: SN], guard_code);
            lh = side_hit(edge_smp_i[l], late_smp_i[l*SN +: SN], guard_code);
            if (rst) begin m_early[l] = 1'b0; m_late[l] = 1'b0; end
            else begin
                m_early[l] = eh ? 1'b1 : (clear_i ? 1'b0 : m_early[l]);
                m_late[l]  = lh ? 1'b1 : (clear_i ? 1'b0 : m_late[l]);
            end
        end
        @(negedge clk);
    endtask

    task automatic quiet();
        edge_smp_i  = '0;
        early_smp_i = '0;
        late_smp_i  = '0;
    endtask

    // one transition at step p on lane ln: samples from index p-1 upward are 1
    function automatic logic [SN-1:0] one_edge(input int p);
        return 8'hFF << (p - 1);
    endfunction

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; clear_i = 1'b0; guard_code = 3'd0;
        edge_smp_i  = '1;
        early_smp_i = 32'h0F0F_0F0F;
        late_smp_i  = 32'hF0F0_F0F0;
        @(negedge clk);
        step(); step();
        check("R10 reset early", early_flag_o, '0);
        check("R10 reset late",  late_flag_o,  '0);
        rst = 1'b0;
        quiet();

        // R1 R3 R4 R5: single transition swept over every code and step
        for (int c = 0; c < 8; c++) begin
            for (int p = 1; p <= SN; p++) begin
                for (int side = 0; side < 2; side++) begin
                    int ln;
                    logic [NL-1:0] exp;
                    ln = p % NL;
                    guard_code = 3'(c);
                    quiet(); clear_i = 1'b1;
                    step();
                    clear_i = 1'b0;
                    if (side == 0) early_smp_i[ln*SN +: SN] = one_edge(p);
                    else           late_smp_i[ln*SN +: SN]  = one_edge(p);
                    step();
                    exp = (p <= exp_len(3'(c))) ? NL'(1) << ln : '0;
                    if (side == 0) begin
                        check("R3 R5 R1 early step", early_flag_o, exp);
                        check("R4 late untouched", late_flag_o, '0);
                    end else begin
                        check("R4 R5 R1 late step", late_flag_o, exp);
                        check("R3 early untouched", early_flag_o, '0);
                    end
                end
            end
        end

        // R6 sticky, R7 clear, R8 detect beats clear, R9 both sides
        guard_code = 3'd2;
        quiet(); clear_i = 1'b1; step(); clear_i = 1'b0;
        edge_smp_i[1] = 1'b1;            // lane 1: both sides differ at step 1
        early_smp_i[1*SN +: SN] = 8'h00;
        late_smp_i[1*SN +: SN]  = 8'h00;
        early_smp_i[1*SN +: SN] = 8'h00;
        step();
        check("R9 both early", early_flag_o, 4'b0010);
        check("R9 both late",  late_flag_o,  4'b0010);
        quiet();
        step(); step();
        check("R6 hold early", early_flag_o, 4'b0010);
        check("R6 hold late",  late_flag_o,  4'b0010);
        early_smp_i[3*SN +: SN] = 8'h02; // lane 3 step 2 and 3 differ
        clear_i = 1'b1;
        step();
        check("R8 detect wins", early_flag_o, 4'b1000);
        check("R7 clear late",  late_flag_o,  4'b0000);
        clear_i = 1'b0; quiet();

        // R11: width change in the same cycle as the samples
        guard_code = 3'd5;
        early_smp_i[0 +: SN] = one_edge(7);
        clear_i = 1'b1; step(); clear_i = 1'b0;
        check("R11 code5 ignores step7", early_flag_o, 4'b0000);
        guard_code = 3'd6;
        step();
        check("R11 code6 sees step7", early_flag_o, 4'b0001);
        quiet(); clear_i = 1'b1; step(); clear_i = 1'b0;
        check("R7 clear all", early_flag_o, 4'b0000);

        // R2 R3 R4 R6 R7 R8 R9: random sparse patterns against the model
        m_early = early_flag_o;
        m_late  = late_flag_o;
        void'($urandom(32'd4242));
        for (int i = 0; i < 3000; i++) begin
            guard_code = 3'($urandom);
            clear_i    = ($urandom % 8) == 0;
            edge_smp_i = NL'($urandom);
            for (int l = 0; l < NL; l++) begin
                logic [SN-1:0] ef, lf;
                ef = 8'($urandom) & 8'($urandom) & 8'($urandom) & 8'($urandom);
                lf = 8'($urandom) & 8'($urandom) & 8'($urandom) & 8'($urandom);
                early_smp_i[l*SN +: SN] = {SN{edge_smp_i[l]}} ^ ef;
                late_smp_i[l*SN +: SN]  = {SN{edge_smp_i[l]}} ^ lf;
            end
            step();
            check("R2 R3 R6 R7 R8 random early", early_flag_o, m_early);
            check("R2 R4 R6 R7 R9 random late",  late_flag_o,  m_late);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule